// File: doc/BRIEF.md
# Pre-encoded signed-digit coefficient multiplier

This block multiplies a run-time two's complement operand by a coefficient held in a small internal table. The coefficient is not stored in plain binary. It is stored as a ready-made radix-4 signed-digit code, so the datapath needs no recoding stage. Every digit except the top one takes one of only four values and is held in 2 bits. The top digit keeps the full five-value range {-2..+2} and is held as a 3-bit sign/magnitude triple. An N-bit coefficient therefore costs 2(K-1)+3 stored bits, where K = N/2 digits. This is narrower than the 3 bits per digit needed for fully Booth-coded storage.

A build-time parameter picks the low-digit value set. The minus set is {-2,-1,0,+1} and the plus set is {-1,0,+1,+2}. Each digit drives one partial-product generator, so there are K partial products for an N-bit coefficient. A negative digit complements the operand and injects a +1 at that digit's weight. The K partial products and one vector of injected ones are reduced by a carry-save array. A parallel-prefix carry-lookahead adder then resolves the result, and the 2N-bit product is registered.

Codes are written through a simple write port. The bench fills the table with its own encoder.

Top module: `nr4sd_coef_mul`

## Requirements
- R1: While rst_ni is low, prod_o is zero and every table entry is cleared to the all-zero code, which means coefficient 0. A read after reset therefore yields product 0.
- R2: When wr_en_i is high at a rising clock edge, wr_code_i is stored at entry wr_addr_i. A read of that entry in any later cycle uses the new code.
- R3: Low digit j (j = 0..K-2) has weight 4^j and sits in code bits [2j+1:2j]. With the minus set the bit pairs mean 00 = 0, 01 = +1, 10 = -2 and 11 = -1.
- R4: With the plus set the low-digit bit pairs mean 00 = 0, 01 = -1, 10 = +2 and 11 = +1.
- R5: The top digit has weight 4^(K-1). Its code bit CW-1 means negate, bit CW-2 means magnitude 2 and bit CW-3 means magnitude 1, giving values -2..+2.
- R6: Take a_i and the entry at rd_addr_i as sampled at one rising edge. At the next edge, prod_o becomes their exact product, taken modulo 2^(2N) and read as two's complement. An operand of zero gives product zero.
- R7: A write and a read of the same entry in the same cycle give a product computed from the code held before the write.
- R8: A top-digit triple with negate set and both magnitude bits clear counts as digit 0.
- R9: Any N-bit two's complement coefficient, encoded into the selected digit set, gives the exact product for every operand value, including the most negative operand and coefficient.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Table write enable |
| wr_addr_i | input | $clog2(DEPTH) | Table entry to write |
| wr_code_i | input | 2(N/2-1)+3 | Encoded coefficient to store |
| rd_addr_i | input | $clog2(DEPTH) | Table entry used for the multiply |
| a_i | input | N | Two's complement operand |
| prod_o | output | 2N | Registered two's complement product |

## Verification
A table write and a multiply that reads the same entry can fall in the same cycle. The product must then come from the old code. The exhaustive 8-bit pass provokes this on every fill cycle, because it multiplies from the very entry it is writing. The 16-bit plus-set instance provokes it at random through writes and reads spread over a 16-entry table. The reference model records the expected product from its shadow table before it applies the write. Any forwarding of the new code therefore shows up as a mismatch one cycle later.

// File: rtl/nr4sd_pkg.sv
package nr4sd_pkg;
  typedef enum logic {
    DIGITS_MINUS = 1'b0,
    DIGITS_PLUS  = 1'b1
  } digit_set_e;

  function automatic int code_width(input int n);
    return 2 * (n / 2 - 1) + 3;
  endfunction
endpackage

// File: rtl/nr4sd_low_ppg.sv
module nr4sd_low_ppg #(
  parameter int                     N   = 8,
  parameter nr4sd_pkg::digit_set_e  SET = nr4sd_pkg::DIGITS_MINUS
) (
  input  logic [1:0]   code_i,
  input  logic [N-1:0] a_i,
  output logic [N+1:0] pp_o,
  output logic         cin_o
);
  logic [N+1:0] a1, a2;
  assign a1 = {{2{a_i[N-1]}}, a_i};
  assign a2 = {a_i[N-1], a_i, 1'b0};

  if (SET == nr4sd_pkg::DIGITS_MINUS) begin : g_minus
    always_comb begin
      unique case (code_i)
        2'b01:   begin pp_o = a1;  cin_o = 1'b0; end
        2'b10:   begin pp_o = ~a2; cin_o = 1'b1; end
        2'b11:   begin pp_o = ~a1; cin_o = 1'b1; end
        default: begin pp_o = '0;  cin_o = 1'b0; end
      endcase
    end
  end else begin : g_plus
    always_comb begin
      unique case (code_i)
        2'b01:   begin pp_o = ~a1; cin_o = 1'b1; end
        2'b10:   begin pp_o = a2;  cin_o = 1'b0; end
        2'b11:   begin pp_o = a1;  cin_o = 1'b0; end
        default: begin pp_o = '0;  cin_o = 1'b0; end
      endcase
    end
  end
endmodule

// File: rtl/nr4sd_top_ppg.sv
module nr4sd_top_ppg #(
  parameter int N = 8
) (
  input  logic         neg_i,
  input  logic         two_i,
  input  logic         one_i,
  input  logic [N-1:0] a_i,
  output logic [N+1:0] pp_o,
  output logic         cin_o
);
  logic [N+1:0] sel;

  always_comb begin
    if (two_i)      sel = {a_i[N-1], a_i, 1'b0};
    else if (one_i) sel = {{2{a_i[N-1]}}, a_i};
    else            sel = '0;
    // negate with zero magnitude: ~0 + 1 wraps to 0
    pp_o  = neg_i ? ~sel : sel;
    cin_o = neg_i;
  end
endmodule

// File: rtl/nr4sd_csa_reduce.sv
module nr4sd_csa_reduce #(
  parameter int W = 16,
  parameter int M = 5   // operand count, at least 3
) (
  input  logic [M-1:0][W-1:0] ops_i,
  output logic [W-1:0]        sum_o,
  output logic [W-1:0]        carry_o
);
  always_comb begin
    logic [W-1:0] s, c, s_n;
    s = ops_i[0];
    c = ops_i[1];
    for (int i = 2; i < M; i++) begin
      s_n = s ^ c ^ ops_i[i];
      c   = ((s & c) | (s & ops_i[i]) | (c & ops_i[i])) << 1;
      s   = s_n;
    end
    sum_o   = s;
    carry_o = c;
  end
endmodule

// File: rtl/nr4sd_prefix_adder.sv
module nr4sd_prefix_adder #(
  parameter int W = 16
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  output logic [W-1:0] sum_o
);
  localparam int LVLS = $clog2(W);

  always_comb begin
    logic [W-1:0] g, p, g_n, p_n, p0;
    p0 = x_i ^ y_i;
    g  = x_i & y_i;
    p  = p0;
    for (int l = 0; l < LVLS; l++) begin
      g_n = g;
      p_n = p;
      for (int b = (1 << l); b < W; b++) begin
        g_n[b] = g[b] | (p[b] & g[b-(1<<l)]);
        p_n[b] = p[b] & p[b-(1<<l)];
      end
      g = g_n;
      p = p_n;
    end
    sum_o = p0 ^ (g << 1);
  end
endmodule

// File: rtl/nr4sd_coef_mul.sv
module nr4sd_coef_mul #(
  parameter int                    N     = 8,
  parameter int                    DEPTH = 16,
  parameter nr4sd_pkg::digit_set_e SET   = nr4sd_pkg::DIGITS_MINUS
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic                                 wr_en_i,
  input  logic [$clog2(DEPTH)-1:0]             wr_addr_i,
  input  logic [nr4sd_pkg::code_width(N)-1:0]  wr_code_i,
  input  logic [$clog2(DEPTH)-1:0]             rd_addr_i,
  input  logic [N-1:0]                         a_i,
  output logic [2*N-1:0]                       prod_o
);
  localparam int K  = N / 2;
  localparam int CW = nr4sd_pkg::code_width(N);
  localparam int PW = 2 * N;
  localparam int GW = N + 2;

  logic [CW-1:0]         mem_q [DEPTH];
  logic [CW-1:0]         rd_code;
  logic [K-1:0][GW-1:0]  pp;
  logic [K-1:0]          cin;
  logic [K:0][PW-1:0]    ops;
  logic [PW-1:0]         cin_vec, red_s, red_c, sum;
  logic [PW-1:0]         prod_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (wr_en_i) begin
      mem_q[wr_addr_i] <= wr_code_i;
    end
  end

  assign rd_code = mem_q[rd_addr_i];

  for (genvar j = 0; j < K - 1; j++) begin : g_low
    nr4sd_low_ppg #(.N(N), .SET(SET)) u_ppg (
      .code_i (rd_code[2*j+1:2*j]),
      .a_i    (a_i),
      .pp_o   (pp[j]),
      .cin_o  (cin[j])
    );
  end

  nr4sd_top_ppg #(.N(N)) u_top_ppg (
    .neg_i  (rd_code[CW-1]),
    .two_i  (rd_code[CW-2]),
    .one_i  (rd_code[CW-3]),
    .a_i    (a_i),
    .pp_o   (pp[K-1]),
    .cin_o  (cin[K-1])
  );

  for (genvar j = 0; j < K; j++) begin : g_align
    assign ops[j] = {{(PW-GW){pp[j][GW-1]}}, pp[j]} << (2 * j);
  end

  always_comb begin
    cin_vec = '0;
    for (int j = 0; j < K; j++) cin_vec[2*j] = cin[j];
  end
  assign ops[K] = cin_vec;

  nr4sd_csa_reduce #(.W(PW), .M(K + 1)) u_csa (
    .ops_i   (ops),
    .sum_o   (red_s),
    .carry_o (red_c)
  );

  nr4sd_prefix_adder #(.W(PW)) u_cla (
    .x_i   (red_s),
    .y_i   (red_c),
    .sum_o (sum)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prod_q <= '0;
    else         prod_q <= sum;
  end

  assign prod_o = prod_q;
endmodule

// File: rtl/nr4sd_coef_mul_chk.sv
module nr4sd_coef_mul_chk #(
  parameter int                    N     = 8,
  parameter int                    DEPTH = 16,
  parameter nr4sd_pkg::digit_set_e SET   = nr4sd_pkg::DIGITS_MINUS
) (
  input logic                                clk_i,
  input logic                                rst_ni,
  input logic                                wr_en_i,
  input logic [$clog2(DEPTH)-1:0]            wr_addr_i,
  input logic [nr4sd_pkg::code_width(N)-1:0] wr_code_i,
  input logic [$clog2(DEPTH)-1:0]            rd_addr_i,
  input logic [N-1:0]                        a_i,
  input logic [nr4sd_pkg::code_width(N)-1:0] rd_code_i,
  input logic [2*N-1:0]                      prod_o
);
  localparam int K  = N / 2;
  localparam int CW = nr4sd_pkg::code_width(N);
  localparam int PW = 2 * N;

  logic [PW-1:0] exp_prod;

  always_comb begin
    longint coef, d, prod_l;
    coef = 0;
    for (int j = 0; j < K - 1; j++) begin
      if (SET == nr4sd_pkg::DIGITS_MINUS)
        d = longint'(rd_code_i[2*j]) - 2 * longint'(rd_code_i[2*j+1]);
      else
        d = 2 * longint'(rd_code_i[2*j+1]) - longint'(rd_code_i[2*j]);
      coef = coef + (d <<< (2 * j));
    end
    d = rd_code_i[CW-2] ? 2 : (rd_code_i[CW-3] ? 1 : 0);
    if (rd_code_i[CW-1]) d = -d;
    coef   = coef + (d <<< (2 * (K - 1)));
    prod_l = longint'($signed(a_i)) * coef;
    exp_prod = prod_l[PW-1:0];
  end

  AST_RESET_CLEAR: assert property (@(posedge clk_i)
    !rst_ni |-> prod_o == '0);  // R1

  AST_WRITE_VISIBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (rd_addr_i != $past(wr_addr_i)) || (rd_code_i == $past(wr_code_i)));  // R2

  AST_PRODUCT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> prod_o == $past(exp_prod));  // R6

  AST_ZERO_OPERAND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_i == '0) |=> prod_o == '0);  // R6

  AST_READ_OLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == rd_addr_i) |=> prod_o == $past(exp_prod));  // R7

  AST_NEG_ZERO_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_code_i == {1'b1, {(CW-1){1'b0}}}) |=> prod_o == '0);  // R8
endmodule

bind nr4sd_coef_mul nr4sd_coef_mul_chk #(.N(N), .DEPTH(DEPTH), .SET(SET)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .wr_addr_i (wr_addr_i),
  .wr_code_i (wr_code_i),
  .rd_addr_i (rd_addr_i),
  .a_i       (a_i),
  .rd_code_i (rd_code),
  .prod_o    (prod_o)
);

// File: tb/tb_nr4sd_coef_mul.sv
`timescale 1ns/1ps
module tb_nr4sd_coef_mul;
  localparam int CW8  = 9;
  localparam int CW16 = 17;

  logic clk = 1'b0;
  logic rst_n;
  always #4 clk = ~clk;

  logic            wr_en8 = 0, wr_en16 = 0;
  logic [3:0]      wr_addr8 = 0, wr_addr16 = 0, rd_addr8 = 0, rd_addr16 = 0;
  logic [CW8-1:0]  wr_code8 = 0;
  logic [CW16-1:0] wr_code16 = 0;
  logic [7:0]      a8 = 0;
  logic [15:0]     a16 = 0;
  logic [15:0]     prod8;
  logic [31:0]     prod16;

  nr4sd_coef_mul #(.N(8), .DEPTH(16), .SET(nr4sd_pkg::DIGITS_MINUS)) dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en8), .wr_addr_i(wr_addr8),
    .wr_code_i(wr_code8), .rd_addr_i(rd_addr8), .a_i(a8), .prod_o(prod8));

  nr4sd_coef_mul #(.N(16), .DEPTH(16), .SET(nr4sd_pkg::DIGITS_PLUS)) dut16 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en16), .wr_addr_i(wr_addr16),
    .wr_code_i(wr_code16), .rd_addr_i(rd_addr16), .a_i(a16), .prod_o(prod16));

  int     n_cmp = 0, n_bad = 0;
  bit     done = 0;
  longint sh8 [16];
  longint sh16 [16];
  logic [15:0] exp8;
  logic [31:0] exp16;
  bit     pend8 = 0, pend16 = 0;
  string  tag8, tag16;

  // behavioural encoder: minus or plus low digits, Booth top digit
  function automatic logic [31:0] enc(input longint v, input bit plus, input int n);
    logic [31:0] code = '0;
    int k = n / 2;
    int c = 0;
    int b0, b1, t, d;
    for (int j = 0; j < k - 1; j++) begin
      b0 = int'((v >>> (2*j)) & 1);
      b1 = int'((v >>> (2*j+1)) & 1);
      if (!plus) begin
        code[2*j] = b0 ^ c;
        t = b1 + (b0 & c);
        code[2*j+1] = (t == 1);
        c = (t != 0);
      end else begin
        t = b0 + c;
        code[2*j] = (t == 1);
        code[2*j+1] = b1 ^ (t != 0);
        c = b1 & (t != 0);
      end
    end
    d = -2 * int'((v >>> (n-1)) & 1) + int'((v >>> (n-2)) & 1) + c;
    code[2*(k-1)+2] = (d < 0);
    code[2*(k-1)+1] = (d == 2 || d == -2);
    code[2*(k-1)]   = (d == 1 || d == -1);
    return code;
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] expv, input string tag);
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  task automatic drive8(input bit we, input int waddr, input logic [CW8-1:0] code,
                        input longint val, input int raddr, input longint a, input string tag);
    longint p;
    wr_en8 = we; wr_addr8 = waddr[3:0]; wr_code8 = code;
    rd_addr8 = raddr[3:0]; a8 = a[7:0];
    p = longint'($signed(a8)) * sh8[raddr];
    exp8 = p[15:0]; tag8 = tag; pend8 = 1;
    if (we) sh8[waddr] = val;
  endtask

  task automatic rnd16();
    longint p, v;
    logic [31:0] c;
    int waddr = $urandom % 16;
    int raddr = $urandom % 16;
    bit we = ($urandom % 4) == 0;
    v = longint'($signed(16'($urandom)));
    c = enc(v, 1'b1, 16);
    wr_en16 = we; wr_addr16 = waddr[3:0]; wr_code16 = c[CW16-1:0];
    rd_addr16 = raddr[3:0]; a16 = 16'($urandom);
    p = longint'($signed(a16)) * sh16[raddr];
    exp16 = p[31:0];
    tag16 = (we && waddr == raddr) ? "R7 (plus set)" : "R4 R6";
    pend16 = 1;
    if (we) sh16[waddr] = v;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    if (pend8)  check({16'h0, prod8}, {16'h0, exp8}, tag8);
    if (pend16) check(prod16, exp16, tag16);
  endtask

  task automatic cyc8(input bit we, input int waddr, input logic [CW8-1:0] code,
                      input longint val, input int raddr, input longint a, input string tag);
    drive8(we, waddr, code, val, raddr, a, tag);
    rnd16();
    step();
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] c;
    for (int i = 0; i < 16; i++) begin sh8[i] = 0; sh16[i] = 0; end
    rst_n = 1'b1;
    #1 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check({16'h0, prod8}, 32'h0, "R1 during reset");
    check(prod16, 32'h0, "R1 during reset");
    rst_n = 1'b1;

    // R1: table cleared, products zero
    for (int i = 0; i < 16; i++) cyc8(0, 0, '0, 0, i, 77, "R1");

    // R2: write then read the entry next cycle
    c = enc(37, 1'b0, 8);
    cyc8(1, 5, c[CW8-1:0], 37, 0, -9, "R2");
    cyc8(0, 0, '0, 0, 5, -9, "R2");

    // R3: minus digit codes 10,11,01 in digits 0..2 give -2-4+16 = 10
    cyc8(1, 6, 9'b000_01_11_10, 10, 0, 3, "R3");
    cyc8(0, 0, '0, 0, 6, 3, "R3");
    cyc8(0, 0, '0, 0, 6, -128, "R3");

    // R5: top digit alone, +2, -2, +1
    cyc8(1, 7, 9'b010_000000, 128, 0, 1, "R5");
    cyc8(1, 8, 9'b110_000000, -128, 7, -128, "R5");
    cyc8(1, 9, 9'b001_000000, 64, 8, -128, "R5");
    cyc8(0, 0, '0, 0, 9, 127, "R5");

    // R8: negate with zero magnitude
    cyc8(1, 10, 9'b100_000000, 0, 0, 1, "R8");
    cyc8(1, 11, 9'b100_000001, 1, 10, -77, "R8");
    cyc8(0, 0, '0, 0, 11, -77, "R8");

    // R9 / R7: exhaustive 8-bit, minus set; fill reads the entry being written
    for (int g = 0; g < 16; g++) begin
      for (int i = 0; i < 16; i++) begin
        longint v = longint'(g * 16 + i - 128);
        c = enc(v, 1'b0, 8);
        cyc8(1, i, c[CW8-1:0], v, i, longint'($signed(8'($urandom))), "R7");
      end
      for (int r = 0; r < 16; r++)
        for (int a = -128; a < 128; a++)
          cyc8(0, 0, '0, 0, r, a, "R9");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule